// File: doc/BRIEF.md
# Nonblocking Direct-Mapped Read Cache with Line-Fill Buffer

This block is a 2-Kbyte, direct-mapped read cache placed between a core's 32-bit local bus and an external memory port that returns data in four-beat bursts. The core presents a longword address and holds its request until the cache raises a ready strobe. In that same cycle the cache drives the data. Each lookup checks the line array and a separate one-line fill buffer in parallel. A hit in either completes in the cycle it is presented.

When a lookup misses both, the cache starts one burst for the whole 16-byte line. The burst begins at the missing longword and wraps within the line. The fill buffer records each longword as it arrives, with one valid bit per longword. The waiting request completes as soon as its own word is present. The core can then go on with other accesses while the rest of the line arrives. A full buffer is copied into the array in one cycle, which sets that line's single valid bit. A synchronous invalidate-all input walks the array once, clearing every line valid bit.

Top module: `lfb_cache`

## Requirements
- R1: A request whose line is valid in the array with a matching tag gets `coreReady` high and the stored longword on `coreData` in the cycle it is presented. Address split: `coreWordAddr[1:0]` picks the longword within the line, `[8:2]` is the line index, and the upper bits form the tag.
- R2: A request that misses both the array and the fill buffer raises `memReq` for one cycle, with `memAddr` equal to the requested longword address. The memory returns four beats on `memValid`/`memData` in the order start, start+1, start+2, start+3, taken modulo 4 within the line.
- R3: The missing request completes one cycle after its first beat is delivered, with that beat's data.
- R4: While a burst is in progress, a request to a valid array line, or to a longword of the filling line that has already arrived, completes in the cycle it is presented and starts no burst.
- R5: After the fourth beat, the buffered line is written into the array at its index and marked valid. The line then keeps hitting after the buffer has moved on to another line.
- R6: A miss to a different line during a burst stalls the core. `memReq` stays low until the current burst and its array write have finished, and then a single new burst serves the stalled request.
- R7: Two lines with the same index and different tags evict each other, so alternating between them misses every time.
- R8: A one-cycle pulse on `invAll` holds off every core request until all 128 line valid bits and the buffer valid bits are cleared. This finishes within 132 cycles of the pulse when no burst is active, and previously cached lines then miss.
- R9: After reset, `coreReady` and `memReq` are low while no request is presented, and the first access to any line misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| invAll | input | 1 | Pulse to invalidate the whole cache |
| coreReq | input | 1 | Core fetch request, held until ready |
| coreWordAddr | input | ADDR_W-2 | Longword address of the fetch |
| coreReady | output | 1 | Fetch completes this cycle |
| coreData | output | 32 | Fetched longword, valid with coreReady |
| memReq | output | 1 | One-cycle burst start |
| memAddr | output | ADDR_W-2 | Longword address of the first beat |
| memValid | input | 1 | A burst beat is present |
| memData | input | 32 | Burst beat data |

## Verification
The bench builds the cache with its default parameters: 32-bit addresses and 128 lines. With these values the full invalidate walk, with its 128-cycle hold-off, finishes well inside the run. The memory model returns the first beat two cycles after the request, so the bench can predict the exact stall of a miss. It can also reach the cycles in the middle of a fill, when some words of the line are present and others are not. Line addresses are chosen so that two of them share index 0 and differ only in tag bit 9, which exercises eviction.

// File: rtl/lfbc_pkg.sv
package lfbc_pkg;
  typedef struct packed {
    logic startFill;  // open the buffer for a new line
    logic commit;     // copy full buffer into the array
    logic invStep;    // clear one line valid bit
  } ctrl_strobe_t;
endpackage

// File: rtl/lfbc_datapath.sv
module lfbc_datapath
  import lfbc_pkg::*;
#(
  parameter int AW     = 30,
  parameter int LINES  = 128,
  parameter int WORD_W = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctrl_strobe_t             strb,
  input  logic [$clog2(LINES)-1:0] invIdx,
  input  logic [AW-1:0]            reqAddr,
  input  logic                     memValid,
  input  logic [WORD_W-1:0]        memData,
  output logic                     arrayHit,
  output logic                     fbHit,
  output logic                     fbFull,
  output logic [WORD_W-1:0]        rdData
);
  localparam int IDX_W   = $clog2(LINES);
  localparam int LINE_W  = AW - 2;
  localparam int TAG_W   = LINE_W - IDX_W;
  localparam int WORDS   = LINES * 4;

  logic [TAG_W-1:0]  tagMem  [LINES];
  logic [LINES-1:0]  lineValid;
  logic [WORD_W-1:0] dataMem [WORDS];

  logic [LINE_W-1:0] fbLine;
  logic [WORD_W-1:0] fbWord [4];
  logic [3:0]        fbValid;
  logic [1:0]        beatPtr;

  logic [IDX_W-1:0]  reqIdx, fbIdx;
  logic [TAG_W-1:0]  reqTag;
  logic [LINE_W-1:0] reqLine;
  logic [1:0]        reqWord;

  assign reqWord = reqAddr[1:0];
  assign reqLine = reqAddr[AW-1:2];
  assign reqIdx  = reqLine[IDX_W-1:0];
  assign reqTag  = reqLine[LINE_W-1:IDX_W];
  assign fbIdx   = fbLine[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) lineValid <= '0;
    else if (strb.invStep) lineValid[invIdx] <= 1'b0;
    else if (strb.commit)  lineValid[fbIdx]  <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.commit) begin
      tagMem[fbIdx] <= fbLine[LINE_W-1:IDX_W];
      for (int w = 0; w < 4; w++) dataMem[{fbIdx, 2'(w)}] <= fbWord[w];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fbValid <= '0;
      fbLine  <= '0;
      beatPtr <= '0;
      for (int w = 0; w < 4; w++) fbWord[w] <= '0;
    end else if (strb.invStep) begin
      fbValid <= '0;
    end else if (strb.startFill) begin
      fbLine  <= reqLine;
      fbValid <= '0;
      beatPtr <= reqWord;
    end else if (memValid) begin
      fbWord[beatPtr]  <= memData;
      fbValid[beatPtr] <= 1'b1;
      beatPtr          <= beatPtr + 2'd1;
    end
  end

  assign arrayHit = lineValid[reqIdx] && (tagMem[reqIdx] == reqTag);
  assign fbHit    = (fbLine == reqLine) && fbValid[reqWord];
  assign fbFull   = &fbValid;
  assign rdData   = arrayHit ? dataMem[reqAddr[IDX_W+1:0]] : fbWord[reqWord];

  // R5: the array is only written from a complete buffer
  p_commit_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.commit |-> fbFull);
  // R5: a committed line is valid afterwards
  p_line_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.commit |=> lineValid[$past(fbIdx)]);
endmodule

// File: rtl/lfbc_ctrl.sv
module lfbc_ctrl
  import lfbc_pkg::*;
#(
  parameter int LINES = 128
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     invAll,
  input  logic                     coreReq,
  input  logic                     arrayHit,
  input  logic                     fbHit,
  input  logic                     fbFull,
  output ctrl_strobe_t             strb,
  output logic [$clog2(LINES)-1:0] invIdx,
  output logic                     coreReady,
  output logic                     memReq
);
  localparam int IDX_W = $clog2(LINES);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_COMMIT, S_INV} state_t;
  state_t state;
  logic invPend, anyHit, holdOff;
  logic [IDX_W-1:0] invCnt;

  assign anyHit    = arrayHit || fbHit;
  assign holdOff   = invPend || (state == S_INV);
  assign coreReady = coreReq && anyHit && !holdOff;

  always_comb begin
    strb           = '0;
    strb.startFill = (state == S_IDLE) && !invPend && coreReq && !anyHit;
    strb.commit    = (state == S_COMMIT);
    strb.invStep   = (state == S_INV);
  end
  assign memReq = strb.startFill;
  assign invIdx = invCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      invPend <= 1'b0;
      invCnt  <= '0;
    end else begin
      if (state == S_IDLE && invPend) invPend <= invAll;
      else if (invAll)                invPend <= 1'b1;
      unique case (state)
        S_IDLE: begin
          if (invPend) begin
            state  <= S_INV;
            invCnt <= '0;
          end else if (strb.startFill) begin
            state <= S_FILL;
          end
        end
        S_FILL:   if (fbFull) state <= S_COMMIT;
        S_COMMIT: state <= S_IDLE;
        S_INV: begin
          invCnt <= invCnt + 1'b1;
          if (invCnt == IDX_W'(LINES - 1)) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1: ready is only given to a presented request
  p_ready_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    coreReady |-> coreReq);
  // R8: no fetch completes while the array is being cleared
  p_inv_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_INV) |-> !coreReady);
  // R5: a full buffer is committed on the next cycle
  p_fill_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FILL && fbFull) |=> strb.commit);
  // R6: bursts never start back to back
  p_burst_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    memReq |=> !memReq);
endmodule

// File: rtl/lfb_cache.sv
module lfb_cache
  import lfbc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LINES  = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              invAll,
  input  logic              coreReq,
  input  logic [ADDR_W-3:0] coreWordAddr,
  output logic              coreReady,
  output logic [31:0]       coreData,
  output logic              memReq,
  output logic [ADDR_W-3:0] memAddr,
  input  logic              memValid,
  input  logic [31:0]       memData
);
  localparam int AW    = ADDR_W - 2;
  localparam int IDX_W = $clog2(LINES);

  ctrl_strobe_t     strb;
  logic [IDX_W-1:0] invIdx;
  logic             arrayHit, fbHit, fbFull;

  lfbc_ctrl #(.LINES(LINES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .invAll(invAll), .coreReq(coreReq),
    .arrayHit(arrayHit), .fbHit(fbHit), .fbFull(fbFull),
    .strb(strb), .invIdx(invIdx), .coreReady(coreReady), .memReq(memReq)
  );

  lfbc_datapath #(.AW(AW), .LINES(LINES), .WORD_W(32)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .invIdx(invIdx),
    .reqAddr(coreWordAddr), .memValid(memValid), .memData(memData),
    .arrayHit(arrayHit), .fbHit(fbHit), .fbFull(fbFull), .rdData(coreData)
  );

  assign memAddr = coreWordAddr;
endmodule

// File: tb/tb_lfb_cache.sv
module tb_lfb_cache;
  localparam int LAT = 2;

  logic        clk = 0, rst_n = 0, invAll = 0, coreReq = 0, memValid = 0;
  logic [29:0] coreWordAddr = '0;
  logic [29:0] memAddr;
  logic        coreReady, memReq;
  logic [31:0] coreData, memData = '0;

  int tests = 0, fails = 0, bursts = 0;
  logic [29:0] lastBurst = '0;
  logic [31:0] expQ[$];

  lfb_cache dut (
    .clk(clk), .rst_n(rst_n), .invAll(invAll), .coreReq(coreReq),
    .coreWordAddr(coreWordAddr), .coreReady(coreReady), .coreData(coreData),
    .memReq(memReq), .memAddr(memAddr), .memValid(memValid), .memData(memData)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] memf(input logic [29:0] wa);
    return ({2'b00, wa} * 32'h9E37_79B9) ^ 32'h1234_5678;
  endfunction

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // memory model: beats wrap from the requested word; R6 window checked inline
  initial begin
    forever begin
      @(negedge clk); #3;
      if (memReq) begin
        logic [29:0] base;
        base = memAddr;
        lastBurst = base;
        bursts++;
        for (int c = 1; c <= LAT + 5; c++) begin
          @(negedge clk); #3;
          check(!memReq, "R6 burst while busy", int'(memReq), 0);
          if (c >= LAT && c <= LAT + 3) begin
            memValid = 1;
            memData  = memf({base[29:2], 2'(base[1:0] + 2'(c - LAT))});
          end else begin
            memValid = 0;
          end
        end
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    #2;
    if (coreReq && coreReady) begin
      if (expQ.size() == 0) begin
        check(0, "R1 unexpected completion", 1, 0);
      end else begin
        logic [31:0] e;
        e = expQ.pop_front();
        tests++;
        if (coreData !== e) begin
          fails++;
          $display("FAIL R1/R2/R3 data actual=%h expected=%h", coreData, e);
        end
      end
    end
  end

  task automatic fetch(input logic [29:0] a, input int minW, input int maxW, input string rq);
    int waits;
    waits = 0;
    expQ.push_back(memf(a));
    coreWordAddr = a;
    coreReq = 1;
    #1;
    while (!coreReady && waits < 3000) begin
      @(negedge clk); #1;
      waits++;
    end
    check(waits >= minW && waits <= maxW, rq, waits, minW);
    @(negedge clk);
    coreReq = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  localparam logic [29:0] A = 30'h402;  // idx 0, word 2
  localparam logic [29:0] E = 30'h602;  // idx 0, other tag
  localparam logic [29:0] B = 30'h415;  // idx 5
  localparam logic [29:0] C = 30'h428;  // idx 10
  localparam logic [29:0] D = 30'h437;  // idx 13
  localparam logic [29:0] F = 30'h445;  // idx 17

  initial begin
    int b0;
    idle(3);
    rst_n = 1;
    idle(2);
    // R9: quiet after reset
    check(coreReady == 0, "R9 ready after reset", int'(coreReady), 0);
    check(memReq == 0, "R9 memReq after reset", int'(memReq), 0);

    // R2/R3/R9: first access misses, completes one cycle after first beat
    b0 = bursts;
    fetch(A, LAT + 1, LAT + 1, "R3 miss latency");
    check(bursts == b0 + 1, "R9 first access bursts", bursts - b0, 1);
    check(lastBurst == A, "R2 burst start address", int'(lastBurst), int'(A));
    // R4: already-arrived word of the filling line hits at once
    fetch(A + 30'd1, 0, 0, "R4 buffer hit during fill");
    fetch(A - 30'd2, 0, 1, "R4 wrapped word during fill");
    check(bursts == b0 + 1, "R4 no extra burst", bursts - b0, 1);
    idle(8);
    // R1: array/buffer hit on remaining word
    fetch(A - 30'd1, 0, 0, "R1 hit same cycle");

    // R5: new line displaces buffer, A must come from the array
    fetch(B, LAT + 1, LAT + 1, "R3 miss B");
    fetch(A, 0, 0, "R4 array hit during fill");
    idle(8);
    b0 = bursts;
    fetch(A + 30'd1, 0, 0, "R5 committed line hit");
    fetch(B - 30'd1, 0, 0, "R5 second line hit");
    check(bursts == b0, "R5 no burst on hit", bursts - b0, 0);

    // R6: stalled miss during a fill
    b0 = bursts;
    fetch(C, LAT + 1, LAT + 1, "R3 miss C");
    fetch(D, 6, 9, "R6 stalled miss");
    check(bursts == b0 + 2, "R6 burst count", bursts - b0, 2);
    check(lastBurst == D, "R2 stalled burst address", int'(lastBurst), int'(D));
    idle(8);

    // R7: same index, different tag
    b0 = bursts;
    fetch(E, LAT + 1, LAT + 1, "R7 conflict miss");
    idle(8);
    fetch(A, LAT + 1, LAT + 1, "R7 evicted line misses");
    check(bursts == b0 + 2, "R7 burst count", bursts - b0, 2);
    idle(8);

    // R8: invalidate all
    fetch(F, LAT + 1, LAT + 1, "R8 prime line");
    idle(8);
    fetch(F, 0, 0, "R8 hit before clear");
    invAll = 1;
    @(negedge clk);
    invAll = 0;
    b0 = bursts;
    fetch(F, 128, 136, "R8 hold-off then miss");
    check(bursts == b0 + 1, "R8 line gone", bursts - b0, 1);
    idle(8);
    fetch(A, LAT + 1, LAT + 1, "R8 other line gone");
    idle(8);
    check(expQ.size() == 0, "R1 scoreboard drained", expQ.size(), 0);
    finish_run();
  end
endmodule